// File: doc/BRIEF.md
# Supply Fault Response Controller

This block decides how a digitally controlled step-down regulator reacts when its input supply sags or its output rises too far. It compares a digitized input-voltage code against an undervoltage level and a sensed-output code against a margin above the target-output code. For each of the two fault kinds it then applies a response picked by configuration inputs. The undervoltage responses are to ignore the fault, to ride through it for a bounded time, or to shut down and retry. The overvoltage responses are to shut down and retry, or to crowbar the output by holding the low-side switch on.

The block drives the run indication, a power-good flag and the enables of the high-side and low-side gate drivers, and it reports when it has latched off. Drivers follow a PWM input while running. A dead-time stage guarantees that the two gate enables are never on together. A latched fault or crowbar is left only through a restart request made while no fault is present. Codes use 10 mV per LSB, so 450 stands for 4.5 V.

Top module: `sfr_ctrl`

## Requirements
- R1: While reset (`rst_n` low) is held, `run_en`, `pgood`, `hs_en`, `ls_en` and `fault_latched` are all low.
- R2: An undervoltage exists when `vin_code` is strictly below the selected level: `uv_sel`=0 picks 450, `uv_sel`=1 picks 1080, and 2 or 3 pick `uv_prog` clamped to the range 285..1600.
- R3: An overvoltage exists when `vout_code*100 > vtgt_code*(100+ov_pct)`, i.e. the output is more than `ov_pct` percent above the target (15 gives the nominal margin; with target 100 the output 115 is no fault and 116 is a fault).
- R4: `pgood` is high exactly when `run_en` is high and no overvoltage is present, and it drops in the same cycle an overvoltage appears on the inputs, whatever the response mode.
- R5: With `uv_mode`=2'b01 an undervoltage has no effect: `run_en` stays high and nothing latches.
- R6: With `uv_mode`=2'b10 the block keeps running through an undervoltage. If the fault is still present, the block latches off on the (`ride_cycles`+2)-th clock edge, counting the first edge that sees the fault as the first. A fault that clears earlier returns it to normal running.
- R7: With `uv_mode`=2'b00 (or 2'b11) for undervoltage, and `ov_mode`=0 for overvoltage, `run_en` drops on the first edge that sees the fault. If the fault persists, the block makes exactly `retry_limit` one-cycle restart attempts whose rising edges are `retry_gap`+2 cycles apart, and then latches. `retry_limit`=0 latches at once.
- R8: `retry_limit` all ones (7) retries without limit and never latches. Once the fault is gone the next attempt stays running.
- R9: With `ov_mode`=1 and `ext_clk` low, an overvoltage sets `fault_latched`, drops `run_en` and holds `ls_en` high with `hs_en` low, regardless of `pwm_in`, until a restart.
- R10: With `ext_clk` high, any `ov_mode` acts as `ov_mode`=0, so an overvoltage never leads to the low-side hold.
- R11: `hs_en` and `ls_en` are never high together, and every change of driver state passes through at least one cycle with both low.
- R12: `restart_req` leaves the latched or crowbar state (`fault_latched` falls) only when no fault is present; a request made during a fault is ignored. After it, `run_req` high restarts the block.
- R13: While running, the driver enables follow `pwm_in`, with `hs_en` for high and `ls_en` for low, one register stage after the state (plus one both-off cycle on a change).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_req | input | 1 | Request to run the converter |
| restart_req | input | 1 | Request to leave a latched fault |
| pwm_in | input | 1 | PWM phase from the modulator, 1 selects the high side |
| ext_clk | input | 1 | Converter runs from an external clock |
| vin_code | input | VW | Digitized input voltage |
| vout_code | input | VW | Digitized sensed output voltage |
| vtgt_code | input | VW | Target output voltage |
| uv_sel | input | 2 | Undervoltage level selection |
| uv_prog | input | VW | Programmed undervoltage level |
| ov_pct | input | PW | Overvoltage margin in percent |
| uv_mode | input | 2 | Undervoltage response |
| ov_mode | input | 1 | Overvoltage response, 1 selects low-side hold |
| ride_cycles | input | DW | Ride-through length |
| retry_gap | input | DW | Restart interval |
| retry_limit | input | RW | Restart attempts, all ones for unlimited |
| pgood | output | 1 | Power good |
| run_en | output | 1 | Converter running |
| hs_en | output | 1 | High-side gate enable |
| ls_en | output | 1 | Low-side gate enable |
| fault_latched | output | 1 | Latched off or crowbar active |

## Verification
The bench builds the block with its default parameters: 12-bit voltage codes, a 7-bit margin, 16-bit interval counters and a 3-bit retry count. With the 3-bit count, the unlimited setting of 7 and a bounded count of 2 can both be run to completion in a few dozen cycles. Ride-through and restart intervals are kept at 3 cycles, so expiry, early clearing and retry spacing all fall in short windows. Random voltage codes placed near the 15-percent margin and around all four undervoltage selections probe the comparison boundaries, next to directed values exactly on them.

// File: rtl/sfr_pkg.sv
package sfr_pkg;

  typedef enum logic [2:0] {
    ST_OFF,
    ST_RUN,
    ST_RIDE,
    ST_HOLD,
    ST_LATCH,
    ST_CROW
  } fsm_e;

  typedef enum logic [1:0] {
    DRV_OFF,
    DRV_HI,
    DRV_LO
  } drv_e;

  localparam logic [1:0] UVM_SHUT   = 2'b00;
  localparam logic [1:0] UVM_IGNORE = 2'b01;
  localparam logic [1:0] UVM_RIDE   = 2'b10;
  localparam logic       OVM_CROW   = 1'b1;

  // Step toward the wanted driver state, never skipping the all-off state.
  function automatic drv_e drv_step(drv_e cur, drv_e want);
    if (cur == want)         return cur;
    else if (cur != DRV_OFF) return DRV_OFF;
    else                     return want;
  endfunction

endpackage

// File: rtl/sfr_detect.sv
module sfr_detect #(
  parameter int VW     = 12,
  parameter int PW     = 7,
  parameter int UV_LO  = 450,
  parameter int UV_HI  = 1080,
  parameter int UV_MIN = 285,
  parameter int UV_MAX = 1600
) (
  input  logic [VW-1:0] vin_code,
  input  logic [VW-1:0] vout_code,
  input  logic [VW-1:0] vtgt_code,
  input  logic [1:0]    uv_sel,
  input  logic [VW-1:0] uv_prog,
  input  logic [PW-1:0] ov_pct,
  output logic          uv_now,
  output logic          ov_now
);

  localparam int MW = ((PW > 7) ? PW : 7) + 1;
  localparam int XW = VW + MW;

  function automatic logic [VW-1:0] uv_level(logic [1:0] sel, logic [VW-1:0] prog);
    case (sel)
      2'd0:    return VW'(UV_LO);
      2'd1:    return VW'(UV_HI);
      default: begin
        if (prog < VW'(UV_MIN))      return VW'(UV_MIN);
        else if (prog > VW'(UV_MAX)) return VW'(UV_MAX);
        else                         return prog;
      end
    endcase
  endfunction

  // Cross-multiplied percent compare, no divider.
  function automatic logic over_margin(logic [VW-1:0] vo, logic [VW-1:0] vt,
                                       logic [PW-1:0] pct);
    logic [XW-1:0] lhs;
    logic [XW-1:0] rhs;
    lhs = XW'(vo) * XW'(100);
    rhs = XW'(vt) * (XW'(100) + XW'(pct));
    return lhs > rhs;
  endfunction

  assign uv_now = vin_code < uv_level(uv_sel, uv_prog);
  assign ov_now = over_margin(vout_code, vtgt_code, ov_pct);

endmodule

// File: rtl/sfr_policy.sv
module sfr_policy
  import sfr_pkg::*;
#(
  parameter int DW = 16,
  parameter int RW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_req,
  input  logic          restart_req,
  input  logic          uv_now,
  input  logic          ov_now,
  input  logic          ext_clk,
  input  logic [1:0]    uv_mode,
  input  logic          ov_mode,
  input  logic [DW-1:0] ride_cycles,
  input  logic [DW-1:0] retry_gap,
  input  logic [RW-1:0] retry_limit,
  output logic          run_en,
  output logic          fault_latched,
  output logic          crowbar_st
);

  localparam logic [RW-1:0] RTY_ALL = '1;

  fsm_e          st_q, st_d;
  logic [DW-1:0] cnt_q, cnt_d;
  logic [RW-1:0] rty_q, rty_d;
  logic          retry_ok;
  logic          ov_crow;
  logic          any_fault;
  fsm_e          shut_to;

  assign retry_ok  = (retry_limit != '0) &&
                     ((retry_limit == RTY_ALL) || (rty_q < retry_limit));
  assign ov_crow   = (ov_mode == OVM_CROW) && !ext_clk;
  assign any_fault = uv_now || ov_now;
  assign shut_to   = retry_ok ? ST_HOLD : ST_LATCH;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    rty_d = rty_q;
    case (st_q)
      ST_OFF: begin
        rty_d = '0;
        if (run_req && !any_fault) st_d = ST_RUN;
      end
      ST_RUN, ST_RIDE: begin
        if (ov_now) begin
          if (ov_crow) st_d = ST_CROW;
          else begin
            st_d  = shut_to;
            cnt_d = '0;
          end
        end else if (uv_now && uv_mode != UVM_IGNORE) begin
          if (uv_mode == UVM_RIDE) begin
            if (st_q == ST_RUN) begin
              st_d  = ST_RIDE;
              cnt_d = '0;
            end else if (cnt_q >= ride_cycles) begin
              st_d = ST_LATCH;
            end else begin
              cnt_d = cnt_q + DW'(1);
            end
          end else begin
            st_d  = shut_to;
            cnt_d = '0;
          end
        end else if (!run_req) begin
          st_d = ST_OFF;
        end else begin
          st_d  = ST_RUN;
          rty_d = '0;
        end
      end
      ST_HOLD: begin
        if (!run_req) begin
          st_d = ST_OFF;
        end else if (cnt_q >= retry_gap) begin
          st_d = ST_RUN;
          if (retry_limit != RTY_ALL) rty_d = rty_q + RW'(1);
        end else begin
          cnt_d = cnt_q + DW'(1);
        end
      end
      ST_LATCH, ST_CROW: begin
        if (restart_req && !any_fault) st_d = ST_OFF;
      end
      default: st_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_OFF;
      cnt_q <= '0;
      rty_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      rty_q <= rty_d;
    end
  end

  assign run_en        = (st_q == ST_RUN) || (st_q == ST_RIDE);
  assign fault_latched = (st_q == ST_LATCH) || (st_q == ST_CROW);
  assign crowbar_st    = (st_q == ST_CROW);

endmodule

// File: rtl/sfr_gate.sv
module sfr_gate
  import sfr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  drv_e want,
  output logic hs_en,
  output logic ls_en
);

  drv_e drv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) drv_q <= DRV_OFF;
    else        drv_q <= drv_step(drv_q, want);
  end

  assign hs_en = (drv_q == DRV_HI);
  assign ls_en = (drv_q == DRV_LO);

endmodule

// File: rtl/sfr_ctrl.sv
module sfr_ctrl
  import sfr_pkg::*;
#(
  parameter int VW     = 12,
  parameter int PW     = 7,
  parameter int DW     = 16,
  parameter int RW     = 3,
  parameter int UV_LO  = 450,
  parameter int UV_HI  = 1080,
  parameter int UV_MIN = 285,
  parameter int UV_MAX = 1600
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_req,
  input  logic          restart_req,
  input  logic          pwm_in,
  input  logic          ext_clk,
  input  logic [VW-1:0] vin_code,
  input  logic [VW-1:0] vout_code,
  input  logic [VW-1:0] vtgt_code,
  input  logic [1:0]    uv_sel,
  input  logic [VW-1:0] uv_prog,
  input  logic [PW-1:0] ov_pct,
  input  logic [1:0]    uv_mode,
  input  logic          ov_mode,
  input  logic [DW-1:0] ride_cycles,
  input  logic [DW-1:0] retry_gap,
  input  logic [RW-1:0] retry_limit,
  output logic          pgood,
  output logic          run_en,
  output logic          hs_en,
  output logic          ls_en,
  output logic          fault_latched
);

  logic uv_now;
  logic ov_now;
  logic crowbar_st;
  drv_e drv_want;

  sfr_detect #(
    .VW(VW), .PW(PW), .UV_LO(UV_LO), .UV_HI(UV_HI),
    .UV_MIN(UV_MIN), .UV_MAX(UV_MAX)
  ) u_detect (
    .vin_code (vin_code),
    .vout_code(vout_code),
    .vtgt_code(vtgt_code),
    .uv_sel   (uv_sel),
    .uv_prog  (uv_prog),
    .ov_pct   (ov_pct),
    .uv_now   (uv_now),
    .ov_now   (ov_now)
  );

  sfr_policy #(.DW(DW), .RW(RW)) u_policy (
    .clk          (clk),
    .rst_n        (rst_n),
    .run_req      (run_req),
    .restart_req  (restart_req),
    .uv_now       (uv_now),
    .ov_now       (ov_now),
    .ext_clk      (ext_clk),
    .uv_mode      (uv_mode),
    .ov_mode      (ov_mode),
    .ride_cycles  (ride_cycles),
    .retry_gap    (retry_gap),
    .retry_limit  (retry_limit),
    .run_en       (run_en),
    .fault_latched(fault_latched),
    .crowbar_st   (crowbar_st)
  );

  always_comb begin
    if (crowbar_st)  drv_want = DRV_LO;
    else if (run_en) drv_want = pwm_in ? DRV_HI : DRV_LO;
    else             drv_want = DRV_OFF;
  end

  sfr_gate u_gate (
    .clk  (clk),
    .rst_n(rst_n),
    .want (drv_want),
    .hs_en(hs_en),
    .ls_en(ls_en)
  );

  // Power good falls combinationally with the overvoltage detection.
  assign pgood = run_en && !ov_now;

endmodule

// File: rtl/sfr_ctrl_chk.sv
module sfr_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic hs_en,
  input logic ls_en,
  input logic pgood,
  input logic run_en,
  input logic ov_now,
  input logic uv_now,
  input logic ext_clk,
  input logic ov_mode,
  input logic crowbar_st,
  input logic fault_latched,
  input logic restart_req
);

  // R11
  gate_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_en && ls_en));

  // R11
  hs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hs_en |=> !ls_en);

  // R11
  ls_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ls_en |=> !hs_en);

  // R4
  pg_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ov_now |-> !pgood);

  // R7
  ov_shut_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ov_now && run_en && (ext_clk || !ov_mode)) |=> !run_en);

  // R10
  ext_nocrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_clk && ov_now && !crowbar_st) |=> !crowbar_st);

  // R9
  crow_hs_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    crowbar_st |=> !hs_en);

  // R12
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_latched && !restart_req) |=> fault_latched);

  // R12
  latch_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_latched && (uv_now || ov_now)) |=> fault_latched);

endmodule

bind sfr_ctrl sfr_ctrl_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .hs_en        (hs_en),
  .ls_en        (ls_en),
  .pgood        (pgood),
  .run_en       (run_en),
  .ov_now       (ov_now),
  .uv_now       (uv_now),
  .ext_clk      (ext_clk),
  .ov_mode      (ov_mode),
  .crowbar_st   (crowbar_st),
  .fault_latched(fault_latched),
  .restart_req  (restart_req)
);

// File: tb/sfr_ctrl_tb.sv
`timescale 1ns/100ps
module sfr_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        run_req, restart_req, pwm_in, ext_clk;
  logic [11:0] vin_code, vout_code, vtgt_code, uv_prog;
  logic [1:0]  uv_sel, uv_mode;
  logic [6:0]  ov_pct;
  logic        ov_mode;
  logic [15:0] ride_cycles, retry_gap;
  logic [2:0]  retry_limit;
  logic        pgood, run_en, hs_en, ls_en, fault_latched;

  int checks = 0;
  int failures = 0;
  int dt_bad = 0;
  logic prev_hs = 1'b0;
  logic prev_ls = 1'b0;

  always #2 clk = ~clk;

  sfr_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .run_req(run_req), .restart_req(restart_req),
    .pwm_in(pwm_in), .ext_clk(ext_clk), .vin_code(vin_code),
    .vout_code(vout_code), .vtgt_code(vtgt_code), .uv_sel(uv_sel),
    .uv_prog(uv_prog), .ov_pct(ov_pct), .uv_mode(uv_mode), .ov_mode(ov_mode),
    .ride_cycles(ride_cycles), .retry_gap(retry_gap),
    .retry_limit(retry_limit), .pgood(pgood), .run_en(run_en),
    .hs_en(hs_en), .ls_en(ls_en), .fault_latched(fault_latched)
  );

  // Dead-time monitor for R11, sampled between edges.
  always @(negedge clk) begin
    if (hs_en && ls_en) dt_bad++;
    if ((prev_hs && ls_en) || (prev_ls && hs_en)) dt_bad++;
    prev_hs <= hs_en;
    prev_ls <= ls_en;
  end

  function automatic int uv_ref(int sel, int prog, int vin);
    int lvl;
    if (sel == 0)      lvl = 450;
    else if (sel == 1) lvl = 1080;
    else               lvl = (prog < 285) ? 285 : ((prog > 1600) ? 1600 : prog);
    return (vin < lvl) ? 1 : 0;
  endfunction

  function automatic int ov_ref(int vo, int vt, int pct);
    if (vo <= vt) return 0;
    return ((vo - vt) * 100 > vt * pct) ? 1 : 0;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic recover();
    vin_code    = 12'd2000;
    vout_code   = vtgt_code;
    restart_req = 1'b1;
    cyc(1);
    restart_req = 1'b0;
    cyc(10);
  endtask

  initial begin
    #600000;
    checks++;
    failures++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int rises, first, second, seen_latch;
    logic prev_run;
    void'($urandom(32'd4242));
    rst_n = 1'b0;  run_req = 1'b1;  restart_req = 1'b0;  pwm_in = 1'b1;
    ext_clk = 1'b0;  vin_code = 12'd2000;  vtgt_code = 12'd500;
    vout_code = 12'd500;  uv_sel = 2'd0;  uv_prog = 12'd0;  ov_pct = 7'd15;
    uv_mode = 2'b00;  ov_mode = 1'b0;  ride_cycles = 16'd3;
    retry_gap = 16'd3;  retry_limit = 3'd0;
    cyc(3);
    check("R1 run_en", run_en, 0);
    check("R1 pgood", pgood, 0);
    check("R1 hs_en", hs_en, 0);
    check("R1 ls_en", ls_en, 0);
    check("R1 fault_latched", fault_latched, 0);
    rst_n = 1'b1;
    cyc(1);
    check("R13 run_en start", run_en, 1);
    check("R4 pgood start", pgood, 1);
    cyc(1);
    check("R13 hs_en follows pwm", hs_en, 1);
    pwm_in = 1'b0;
    cyc(1);
    check("R11 both off hs", hs_en, 0);
    check("R11 both off ls", ls_en, 0);
    cyc(1);
    check("R13 ls_en follows pwm", ls_en, 1);
    pwm_in = 1'b1;
    cyc(2);

    // R3 boundary
    vtgt_code = 12'd100;  vout_code = 12'd115;  #0.5;
    check("R3 at margin pgood", pgood, 1);
    vout_code = 12'd116;  #0.5;
    check("R3 above margin pgood", pgood, 0);
    vout_code = 12'd100;
    cyc(1);
    check("R4 pgood back", pgood, 1);

    // R3/R4 random margin probing
    for (int i = 0; i < 60; i++) begin
      int t, p, v;
      t = 100 + int'($urandom % 1000);
      p = int'($urandom % 41);
      v = t - 10 + int'($urandom % (t * p / 100 + 20));
      vtgt_code = 12'(t);  ov_pct = 7'(p);  vout_code = 12'(v);
      #0.5;
      check("R3 random pgood", pgood, 1 - ov_ref(v, t, p));
      vout_code = vtgt_code;
      cyc(1);
    end
    ov_pct = 7'd15;  vtgt_code = 12'd500;  vout_code = 12'd500;
    cyc(1);

    // R2 random thresholds, immediate latch response
    for (int i = 0; i < 40; i++) begin
      int s, pr, v, e;
      s = int'($urandom % 4);  pr = int'($urandom % 2048);
      v = (i < 4) ? ((i % 2 == 0) ? 449 : 450) : int'($urandom % 2048);
      if (i < 4) s = 0;
      uv_sel = 2'(s);  uv_prog = 12'(pr);  vin_code = 12'(v);
      e = uv_ref(s, pr, v);
      cyc(1);
      check("R2 uv run_en", run_en, 1 - e);
      check("R7 zero-retry latch", fault_latched, e);
      uv_sel = 2'd0;
      recover();
    end

    // R5 ignore
    uv_mode = 2'b01;  vin_code = 12'd100;
    cyc(5);
    check("R5 ignore run_en", run_en, 1);
    check("R5 ignore latch", fault_latched, 0);
    vin_code = 12'd2000;  cyc(1);

    // R6 ride-through, cleared early then expiring
    uv_mode = 2'b10;  vin_code = 12'd100;
    cyc(2);
    vin_code = 12'd2000;
    cyc(5);
    check("R6 early clear run_en", run_en, 1);
    check("R6 early clear latch", fault_latched, 0);
    vin_code = 12'd100;
    cyc(4);
    check("R6 still riding", run_en, 1);
    cyc(1);
    check("R6 expired latch", fault_latched, 1);
    check("R6 expired run_en", run_en, 0);

    // R12 restart ignored during fault
    restart_req = 1'b1;  cyc(1);  restart_req = 1'b0;  cyc(1);
    check("R12 restart ignored", fault_latched, 1);
    recover();
    check("R12 restart recovers", run_en, 1);

    // R7 bounded retries
    uv_mode = 2'b00;  retry_limit = 3'd2;  vin_code = 12'd100;
    cyc(1);
    check("R7 immediate shutdown", run_en, 0);
    rises = 0;  first = -1;  second = -1;  prev_run = 1'b0;  seen_latch = 0;
    for (int k = 1; k < 30; k++) begin
      cyc(1);
      if (run_en && !prev_run) begin
        rises++;
        if (first < 0) first = k; else if (second < 0) second = k;
      end
      prev_run = run_en;
    end
    check("R7 attempt count", rises, 2);
    check("R7 attempt spacing", second - first, 5);
    check("R7 latched after attempts", fault_latched, 1);
    recover();

    // R8 unlimited retries
    retry_limit = 3'd7;  vin_code = 12'd100;
    rises = 0;  prev_run = 1'b1;
    for (int k = 0; k < 40; k++) begin
      cyc(1);
      if (run_en && !prev_run) rises++;
      if (fault_latched) seen_latch = 1;
      prev_run = run_en;
    end
    check("R8 many attempts", (rises >= 6) ? 1 : 0, 1);
    check("R8 never latched", seen_latch, 0);
    vin_code = 12'd2000;
    cyc(6);
    check("R8 resumes", run_en, 1);
    cyc(3);
    check("R8 stays running", run_en, 1);
    retry_limit = 3'd0;

    // R9 crowbar
    ov_mode = 1'b1;  vout_code = 12'd700;  #0.5;
    check("R4 pgood drops same cycle", pgood, 0);
    cyc(1);
    check("R9 crowbar latch", fault_latched, 1);
    check("R9 crowbar run_en", run_en, 0);
    cyc(2);
    check("R9 ls held", ls_en, 1);
    check("R9 hs off", hs_en, 0);
    pwm_in = 1'b0;  cyc(1);  pwm_in = 1'b1;  cyc(2);
    check("R9 ls ignores pwm", ls_en, 1);
    restart_req = 1'b1;  cyc(1);  restart_req = 1'b0;  cyc(1);
    check("R12 crowbar kept during fault", ls_en, 1);
    recover();
    check("R12 crowbar cleared", fault_latched, 0);
    check("R13 hs after crowbar", hs_en, 1);

    // R10 external clock forces shutdown
    ext_clk = 1'b1;  vout_code = 12'd700;
    cyc(1);
    check("R10 forced shutdown latch", fault_latched, 1);
    cyc(2);
    check("R10 no low-side hold", ls_en, 0);
    check("R10 high side off", hs_en, 0);
    recover();
    ext_clk = 1'b0;  ov_mode = 1'b0;

    check("R11 dead-time monitor", dt_bad, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule